// File: doc/BRIEF.md
# Instruction Step Sequencer for an 8-bit Processor

This block is the control unit of a small 8-bit processor. Every instruction runs as a series of clocked steps. Two fetch steps come first for every instruction. A tail of steps chosen by the instruction's class follows them. After the last step of the tail, the sequencer goes back to the first fetch step on the next clock. In each step the block drives a vector of named control strobes, which the datapath (PC, register file, ALU, stack pointer, memory and port bus) uses as its enables. The datapath itself lies outside this block.

The opcode input must carry the instruction byte from the instruction-fetch step until the instruction's last step. In practice this means the fetched byte is forwarded while the instruction register loads. The branch step reads the flag inputs in the same cycle, so they must be settled by then. The block has no data stream, so all of its pins are plain level signals with no valid/ready handshake. A halt instruction parks the sequencer in a stop step, and only reset brings it out of that step.

Top module: `ctl_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the step register loads PCADR (code 0). `halted_o` is then 0 and `ctrl_o` shows the PCADR strobes.
- R2: Every instruction starts with PCADR (0) followed by IRLD (1). The class is taken from `ir_op[7:4]` while in IRLD and in every later step.
- R3: Class codes are: 0 nop, 1 alu, 2 cmp, 3 jump, 4 ldi, 5 mov, 6 in, 7 out, 8 call, 9 ret, A push, B pop, F hlt. Codes C, D and E act as nop, so IRLD is followed directly by PCADR.
- R4: alu adds ALU_RUN (2) and then ALU_WB (3). cmp adds ALU_RUN (2) only.
- R5: jump adds PCADR (0) and then BRANCH (4). The jump condition is `ir_op[2:0]`: 0 always, 1 when Z=1, 2 when Z=0, 3 when C=1, 4 when C=0, and 5 to 7 never. In BRANCH, `ctrl_o` bit 2 (pc_load) is 1 exactly when the condition holds.
- R6: ldi adds PCADR (0) and then REG_LD (5). mov adds MV_ADR (6), MV_RD (7) and MV_WR (8).
- R7: in adds PCADR (0), PORT_ADR (9) and PORT_RD (10). out adds PCADR (0), PORT_ADR (9) and PORT_WR (11).
- R8: call adds five steps: PCADR (0), REG_LD (5), SP_ADR (12), RA_PUSH (13) and CALL_GO (14). These fill positions T3 to T7.
- R9: ret adds SP_UP (15), SP_ADR (12) and RA_POP (16). push adds SP_ADR (12) and REG_PUSH (17). pop adds SP_UP (15), SP_ADR (12) and REG_LD (5).
- R10: hlt adds STOP (18). STOP then holds regardless of the opcode until reset, and `halted_o` is 1 exactly while in STOP.
- R11: `ctrl_o` bits are: 0 pc_inc, 1 pc_drv, 2 pc_load, 3 ir_load, 4 reg_wr, 5 reg_drv, 6 alu_drv, 7 flags_upd, 8 adr_load, 9 mem_rd, 10 mem_wr, 11 sp_drv, 12 sp_dec, 13 sp_inc, 14 port_sel, 15 stop. The value for each step is:

| Step | `ctrl_o` |
|---|---|
| PCADR, MV_ADR | 0x0103 |
| IRLD | 0x0208 |
| ALU_RUN | 0x0080 |
| ALU_WB | 0x0050 |
| BRANCH | 0x0200, plus 0x0004 when the jump is taken |
| REG_LD | 0x0210 |
| MV_RD, PORT_ADR | 0x0300 |
| MV_WR | 0x0420 |
| PORT_RD | 0x4210 |
| PORT_WR | 0x4420 |
| SP_ADR | 0x0900 |
| RA_PUSH | 0x1402 |
| CALL_GO | 0x0024 |
| SP_UP | 0x2000 |
| RA_POP | 0x0204 |
| REG_PUSH | 0x1420 |
| STOP | 0x8000 |

- R12: After the final step of any tail, the next step is PCADR (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_op | input | 8 | Opcode of the current instruction, valid from IRLD onward |
| flag_z | input | 1 | Zero flag from the ALU |
| flag_c | input | 1 | Carry flag from the ALU |
| state_o | output | 5 | Code of the current step |
| ctrl_o | output | 16 | Control strobes for the current step |
| halted_o | output | 1 | High while the sequencer is parked in STOP |

## Verification
The current step is held in a register, and each rising edge moves it to the next step. `state_o` therefore shows step k of an instruction exactly k cycles after that instruction's PCADR cycle. `ctrl_o` is a combinational decode of the registered step, plus the live flags in BRANCH, so it is valid in the same cycle as the step it belongs to. The driver applies an instruction in a PCADR cycle and queues one expected (step, strobe) pair for each cycle the instruction should take. The monitor compares one queued pair against the outputs in every cycle, sampling 1 ns after the falling edge. A tail that is too short or too long therefore shows up as a mismatch in the very next cycle.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

  localparam int MAX_BODY = 5;
  localparam int STEP_W   = $clog2(MAX_BODY + 2);
  localparam int ST_W     = 5;
  localparam int CTRL_W   = 16;

  typedef enum logic [ST_W-1:0] {
    ST_PCADR    = 5'd0,
    ST_IRLD     = 5'd1,
    ST_ALU_RUN  = 5'd2,
    ST_ALU_WB   = 5'd3,
    ST_BRANCH   = 5'd4,
    ST_REG_LD   = 5'd5,
    ST_MV_ADR   = 5'd6,
    ST_MV_RD    = 5'd7,
    ST_MV_WR    = 5'd8,
    ST_PORT_ADR = 5'd9,
    ST_PORT_RD  = 5'd10,
    ST_PORT_WR  = 5'd11,
    ST_SP_ADR   = 5'd12,
    ST_RA_PUSH  = 5'd13,
    ST_CALL_GO  = 5'd14,
    ST_SP_UP    = 5'd15,
    ST_RA_POP   = 5'd16,
    ST_REG_PUSH = 5'd17,
    ST_STOP     = 5'd18
  } state_e;

  typedef enum logic [3:0] {
    CL_NOP, CL_ALU, CL_CMP, CL_JMP, CL_LDI, CL_MOV, CL_IN, CL_OUT,
    CL_CALL, CL_RET, CL_PUSH, CL_POP, CL_HLT
  } cls_e;

  localparam int B_PC_INC    = 0;
  localparam int B_PC_DRV    = 1;
  localparam int B_PC_LOAD   = 2;
  localparam int B_IR_LOAD   = 3;
  localparam int B_REG_WR    = 4;
  localparam int B_REG_DRV   = 5;
  localparam int B_ALU_DRV   = 6;
  localparam int B_FLAGS_UPD = 7;
  localparam int B_ADR_LOAD  = 8;
  localparam int B_MEM_RD    = 9;
  localparam int B_MEM_WR    = 10;
  localparam int B_SP_DRV    = 11;
  localparam int B_SP_DEC    = 12;
  localparam int B_SP_INC    = 13;
  localparam int B_PORT_SEL  = 14;
  localparam int B_STOP      = 15;

  function automatic logic [STEP_W-1:0] body_len(cls_e c);
    case (c)
      CL_ALU, CL_JMP, CL_LDI, CL_PUSH:        body_len = 3'd2;
      CL_CMP, CL_HLT:                          body_len = 3'd1;
      CL_MOV, CL_IN, CL_OUT, CL_RET, CL_POP:   body_len = 3'd3;
      CL_CALL:                                 body_len = 3'd5;
      default:                                 body_len = 3'd0;
    endcase
  endfunction

  function automatic state_e body_at(cls_e c, logic [STEP_W-1:0] i);
    body_at = ST_PCADR;
    case (c)
      CL_ALU:  body_at = (i == 0) ? ST_ALU_RUN : ST_ALU_WB;
      CL_CMP:  body_at = ST_ALU_RUN;
      CL_JMP:  body_at = (i == 0) ? ST_PCADR : ST_BRANCH;
      CL_LDI:  body_at = (i == 0) ? ST_PCADR : ST_REG_LD;
      CL_MOV:  body_at = (i == 0) ? ST_MV_ADR : (i == 1) ? ST_MV_RD : ST_MV_WR;
      CL_IN:   body_at = (i == 0) ? ST_PCADR : (i == 1) ? ST_PORT_ADR : ST_PORT_RD;
      CL_OUT:  body_at = (i == 0) ? ST_PCADR : (i == 1) ? ST_PORT_ADR : ST_PORT_WR;
      CL_CALL: case (i)
                 3'd0:    body_at = ST_PCADR;
                 3'd1:    body_at = ST_REG_LD;
                 3'd2:    body_at = ST_SP_ADR;
                 3'd3:    body_at = ST_RA_PUSH;
                 default: body_at = ST_CALL_GO;
               endcase
      CL_RET:  body_at = (i == 0) ? ST_SP_UP : (i == 1) ? ST_SP_ADR : ST_RA_POP;
      CL_PUSH: body_at = (i == 0) ? ST_SP_ADR : ST_REG_PUSH;
      CL_POP:  body_at = (i == 0) ? ST_SP_UP : (i == 1) ? ST_SP_ADR : ST_REG_LD;
      CL_HLT:  body_at = ST_STOP;
      default: body_at = ST_PCADR;
    endcase
  endfunction

endpackage

// File: rtl/ctl_seq_decode.sv
module ctl_seq_decode
  import ctl_seq_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic            flag_z,
  input  logic            flag_c,
  output cls_e            cls,
  output logic            taken
);

  localparam int CLS_LSB = OP_W - 4;

  always_comb begin
    case (op[OP_W-1:CLS_LSB])
      4'h1:    cls = CL_ALU;
      4'h2:    cls = CL_CMP;
      4'h3:    cls = CL_JMP;
      4'h4:    cls = CL_LDI;
      4'h5:    cls = CL_MOV;
      4'h6:    cls = CL_IN;
      4'h7:    cls = CL_OUT;
      4'h8:    cls = CL_CALL;
      4'h9:    cls = CL_RET;
      4'hA:    cls = CL_PUSH;
      4'hB:    cls = CL_POP;
      4'hF:    cls = CL_HLT;
      default: cls = CL_NOP;
    endcase
  end

  always_comb begin
    case (op[2:0])
      3'd0:    taken = 1'b1;
      3'd1:    taken = flag_z;
      3'd2:    taken = ~flag_z;
      3'd3:    taken = flag_c;
      3'd4:    taken = ~flag_c;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/ctl_seq_next.sv
module ctl_seq_next
  import ctl_seq_pkg::*;
(
  input  state_e            cur_state,
  input  logic [STEP_W-1:0] cur_step,
  input  cls_e              cls,
  output state_e            nxt_state,
  output logic [STEP_W-1:0] nxt_step
);

  logic [STEP_W-1:0] body_idx;

  assign body_idx = cur_step - STEP_W'(1);

  always_comb begin
    if (cur_state == ST_STOP) begin
      nxt_state = ST_STOP;
      nxt_step  = cur_step;
    end else if (cur_step == '0) begin
      nxt_state = ST_IRLD;
      nxt_step  = STEP_W'(1);
    end else if (body_idx < body_len(cls)) begin
      nxt_state = body_at(cls, body_idx);
      nxt_step  = cur_step + STEP_W'(1);
    end else begin
      nxt_state = ST_PCADR;
      nxt_step  = '0;
    end
  end

endmodule

// File: rtl/ctl_seq_strobes.sv
module ctl_seq_strobes
  import ctl_seq_pkg::*;
(
  input  state_e            state,
  input  logic              taken,
  output logic [CTRL_W-1:0] ctrl
);

  always_comb begin
    ctrl = '0;
    case (state)
      ST_PCADR, ST_MV_ADR: begin
        ctrl[B_PC_DRV]   = 1'b1;
        ctrl[B_ADR_LOAD] = 1'b1;
        ctrl[B_PC_INC]   = 1'b1;
      end
      ST_IRLD: begin
        ctrl[B_MEM_RD]  = 1'b1;
        ctrl[B_IR_LOAD] = 1'b1;
      end
      ST_ALU_RUN: ctrl[B_FLAGS_UPD] = 1'b1;
      ST_ALU_WB: begin
        ctrl[B_ALU_DRV] = 1'b1;
        ctrl[B_REG_WR]  = 1'b1;
      end
      ST_BRANCH: begin
        ctrl[B_MEM_RD]  = 1'b1;
        ctrl[B_PC_LOAD] = taken;
      end
      ST_REG_LD: begin
        ctrl[B_MEM_RD] = 1'b1;
        ctrl[B_REG_WR] = 1'b1;
      end
      ST_MV_RD, ST_PORT_ADR: begin
        ctrl[B_MEM_RD]   = 1'b1;
        ctrl[B_ADR_LOAD] = 1'b1;
      end
      ST_MV_WR: begin
        ctrl[B_REG_DRV] = 1'b1;
        ctrl[B_MEM_WR]  = 1'b1;
      end
      ST_PORT_RD: begin
        ctrl[B_PORT_SEL] = 1'b1;
        ctrl[B_MEM_RD]   = 1'b1;
        ctrl[B_REG_WR]   = 1'b1;
      end
      ST_PORT_WR: begin
        ctrl[B_PORT_SEL] = 1'b1;
        ctrl[B_REG_DRV]  = 1'b1;
        ctrl[B_MEM_WR]   = 1'b1;
      end
      ST_SP_ADR: begin
        ctrl[B_SP_DRV]   = 1'b1;
        ctrl[B_ADR_LOAD] = 1'b1;
      end
      ST_RA_PUSH: begin
        ctrl[B_PC_DRV] = 1'b1;
        ctrl[B_MEM_WR] = 1'b1;
        ctrl[B_SP_DEC] = 1'b1;
      end
      ST_CALL_GO: begin
        ctrl[B_REG_DRV] = 1'b1;
        ctrl[B_PC_LOAD] = 1'b1;
      end
      ST_SP_UP: ctrl[B_SP_INC] = 1'b1;
      ST_RA_POP: begin
        ctrl[B_MEM_RD]  = 1'b1;
        ctrl[B_PC_LOAD] = 1'b1;
      end
      ST_REG_PUSH: begin
        ctrl[B_REG_DRV] = 1'b1;
        ctrl[B_MEM_WR]  = 1'b1;
        ctrl[B_SP_DEC]  = 1'b1;
      end
      ST_STOP: ctrl[B_STOP] = 1'b1;
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
  import ctl_seq_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   ir_op,
  input  logic              flag_z,
  input  logic              flag_c,
  output logic [ST_W-1:0]   state_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              halted_o
);

  state_e            state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  cls_e              cls;
  logic              taken;

  ctl_seq_decode #(.OP_W(OP_W)) u_dec (
    .op(ir_op), .flag_z(flag_z), .flag_c(flag_c), .cls(cls), .taken(taken)
  );

  ctl_seq_next u_next (
    .cur_state(state_q), .cur_step(step_q), .cls(cls),
    .nxt_state(state_d), .nxt_step(step_d)
  );

  ctl_seq_strobes u_strb (
    .state(state_q), .taken(taken), .ctrl(ctrl_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_PCADR;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign state_o  = state_q;
  assign halted_o = (state_q == ST_STOP);

  AST_FETCH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PCADR && step_q == '0) |=> (state_q == ST_IRLD)); // R2
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |=> (state_q == ST_STOP)); // R10
  AST_BRANCH_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BRANCH) |=> (state_q == ST_PCADR)); // R12
  AST_CALL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CALL_GO) |=> (state_q == ST_PCADR && step_q == '0)); // R8
  AST_PCLOAD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[B_PC_LOAD] |-> (state_q == ST_BRANCH || state_q == ST_CALL_GO
                           || state_q == ST_RA_POP)); // R5
  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= STEP_W'(MAX_BODY + 1)); // R8

endmodule

// File: tb/ctl_sequencer_test.sv
module ctl_sequencer_test;

  localparam logic [4:0] PCADR = 0, IRLD = 1, ALU_RUN = 2, ALU_WB = 3, BRANCH = 4,
    REG_LD = 5, MV_ADR = 6, MV_RD = 7, MV_WR = 8, PORT_ADR = 9, PORT_RD = 10,
    PORT_WR = 11, SP_ADR = 12, RA_PUSH = 13, CALL_GO = 14, SP_UP = 15,
    RA_POP = 16, REG_PUSH = 17, STOP = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ir_op = 8'h00;
  logic        flag_z = 1'b0;
  logic        flag_c = 1'b0;
  logic [4:0]  state_o;
  logic [15:0] ctrl_o;
  logic        halted_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [4:0]  q_st[$];
  logic [15:0] q_ct[$];
  int          q_rq[$];

  always #5 clk = ~clk;

  ctl_sequencer uut (
    .clk(clk), .rst_n(rst_n), .ir_op(ir_op), .flag_z(flag_z), .flag_c(flag_c),
    .state_o(state_o), .ctrl_o(ctrl_o), .halted_o(halted_o)
  );

  function automatic logic [15:0] exp_ctrl(logic [4:0] s, bit tk);
    case (s)
      PCADR, MV_ADR:   return 16'h0103;
      IRLD:            return 16'h0208;
      ALU_RUN:         return 16'h0080;
      ALU_WB:          return 16'h0050;
      BRANCH:          return tk ? 16'h0204 : 16'h0200;
      REG_LD:          return 16'h0210;
      MV_RD, PORT_ADR: return 16'h0300;
      MV_WR:           return 16'h0420;
      PORT_RD:         return 16'h4210;
      PORT_WR:         return 16'h4420;
      SP_ADR:          return 16'h0900;
      RA_PUSH:         return 16'h1402;
      CALL_GO:         return 16'h0024;
      SP_UP:           return 16'h2000;
      RA_POP:          return 16'h0204;
      REG_PUSH:        return 16'h1420;
      STOP:            return 16'h8000;
      default:         return 16'hxxxx;
    endcase
  endfunction

  function automatic bit exp_taken(logic [7:0] op, bit z, bit c);
    case (op[2:0])
      3'd0: return 1'b1;
      3'd1: return z;
      3'd2: return !z;
      3'd3: return c;
      3'd4: return !c;
      default: return 1'b0;
    endcase
  endfunction

  task automatic expect_step(logic [4:0] s, bit tk, int rq);
    q_st.push_back(s);
    q_ct.push_back(exp_ctrl(s, tk));
    q_rq.push_back(rq);
  endtask

  // Called at a falling edge inside a PCADR cycle; waits for the whole instruction.
  task automatic run_ins(logic [7:0] op, bit z, bit c, int rq, int n,
                         logic [4:0] b0, logic [4:0] b1, logic [4:0] b2,
                         logic [4:0] b3, logic [4:0] b4);
    logic [4:0] body [5];
    bit tk;
    body = '{b0, b1, b2, b3, b4};
    tk = exp_taken(op, z, c);
    ir_op = op; flag_z = z; flag_c = c;
    expect_step(PCADR, tk, 2);  // R2
    expect_step(IRLD, tk, 2);   // R2
    for (int i = 0; i < n; i++) expect_step(body[i], tk, rq);
    repeat (2 + n) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (q_st.size() > 0) begin
        logic [4:0]  es;
        logic [15:0] ec;
        int          rq;
        es = q_st.pop_front();
        ec = q_ct.pop_front();
        rq = q_rq.pop_front();
        n_cmp++;
        if (state_o !== es || ctrl_o !== ec || halted_o !== (es == STOP)) begin
          n_bad++;
          $display("FAIL R%0d: state=%0d ctrl=%h halted=%b, expected state=%0d ctrl=%h halted=%b",
                   rq, state_o, ctrl_o, halted_o, es, ec, (es == STOP));
        end
      end
    end
  end

  task automatic direct_check(string tag);
    n_cmp++;
    if (state_o !== PCADR || ctrl_o !== 16'h0103 || halted_o !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: state=%0d ctrl=%h halted=%b, expected state=0 ctrl=0103 halted=0",
               tag, state_o, ctrl_o, halted_o);
    end
  endtask

  initial begin : watchdog
    #1ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #1 direct_check("R1");          // R1: reset value
    rst_n = 1'b1;
    // nop and unknown classes (R3)
    run_ins(8'h00, 0, 0, 3, 0, 0, 0, 0, 0, 0);
    run_ins(8'hC0, 0, 0, 3, 0, 0, 0, 0, 0, 0);
    run_ins(8'hE7, 0, 0, 3, 0, 0, 0, 0, 0, 0);
    // alu and cmp (R4)
    run_ins(8'h10, 0, 0, 4, 2, ALU_RUN, ALU_WB, 0, 0, 0);
    run_ins(8'h20, 0, 0, 4, 1, ALU_RUN, 0, 0, 0, 0);
    // jumps, taken and not taken (R5)
    run_ins(8'h30, 0, 0, 5, 2, PCADR, BRANCH, 0, 0, 0);
    run_ins(8'h31, 1, 0, 5, 2, PCADR, BRANCH, 0, 0, 0);
    run_ins(8'h31, 0, 1, 5, 2, PCADR, BRANCH, 0, 0, 0);
    run_ins(8'h32, 0, 0, 5, 2, PCADR, BRANCH, 0, 0, 0);
    run_ins(8'h32, 1, 1, 5, 2, PCADR, BRANCH, 0, 0, 0);
    run_ins(8'h33, 0, 1, 5, 2, PCADR, BRANCH, 0, 0, 0);
    run_ins(8'h33, 1, 0, 5, 2, PCADR, BRANCH, 0, 0, 0);
    run_ins(8'h34, 1, 0, 5, 2, PCADR, BRANCH, 0, 0, 0);
    run_ins(8'h34, 0, 1, 5, 2, PCADR, BRANCH, 0, 0, 0);
    run_ins(8'h35, 1, 1, 5, 2, PCADR, BRANCH, 0, 0, 0);
    // ldi, mov (R6)
    run_ins(8'h40, 0, 0, 6, 2, PCADR, REG_LD, 0, 0, 0);
    run_ins(8'h50, 0, 0, 6, 3, MV_ADR, MV_RD, MV_WR, 0, 0);
    // in, out (R7)
    run_ins(8'h60, 0, 0, 7, 3, PCADR, PORT_ADR, PORT_RD, 0, 0);
    run_ins(8'h70, 0, 0, 7, 3, PCADR, PORT_ADR, PORT_WR, 0, 0);
    // call (R8)
    run_ins(8'h80, 0, 0, 8, 5, PCADR, REG_LD, SP_ADR, RA_PUSH, CALL_GO);
    // ret, push, pop (R9)
    run_ins(8'h90, 0, 0, 9, 3, SP_UP, SP_ADR, RA_POP, 0, 0);
    run_ins(8'hA0, 0, 0, 9, 2, SP_ADR, REG_PUSH, 0, 0, 0);
    run_ins(8'hB0, 0, 0, 9, 3, SP_UP, SP_ADR, REG_LD, 0, 0);
    // back-to-back after a long tail (R12)
    run_ins(8'h10, 1, 1, 12, 2, ALU_RUN, ALU_WB, 0, 0, 0);
    // halt: sticks while the opcode changes (R10)
    run_ins(8'hF0, 0, 0, 10, 1, STOP, 0, 0, 0, 0);
    ir_op = 8'h10;
    for (int i = 0; i < 4; i++) expect_step(STOP, 1'b0, 10);
    repeat (4) @(negedge clk);
    // reset is the only way out (R1, R10)
    rst_n = 1'b0;
    @(negedge clk);
    #1 direct_check("R10");
    rst_n = 1'b1;
    ir_op = 8'h00;
    run_ins(8'h40, 0, 0, 11, 2, PCADR, REG_LD, 0, 0, 0);  // R11
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule